// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several software localities owns a shared command interface at any moment. Each locality reaches the block through its own 4 KB page of address space: the page number, taken from the address bits just above the page offset, names the locality. A locality writes its one-byte access register to ask for ownership, give it up, or take it by force (seize). Reads of that register show the requester's view of the arbitration state, built from the stored state on every read.

Ownership moves in three ways. A request is granted at once when nobody owns the interface; otherwise it waits in a per-locality request flag. A release passes ownership to the highest-numbered waiting requester, or leaves the interface unowned. A seize lets a higher locality take over from a lower owner, and the displaced owner is marked as having been seized. When a hand-over is due while a command is still running, the block raises an abort request and holds the current owner until an external abort-done strobe arrives. Only then does it switch. A one-cycle event marks every change of owner.

Top module: `loc_arbiter`

## Requirements
- R1: The write and read locality is address bits [PAGE_SHIFT+2:PAGE_SHIFT]. Writes from locality IGN_LOC (default 4) and from localities at or above NUM_LOC change no state. Reads from a locality at or above NUM_LOC return 8'hFF.
- R2: Writing the request bit (bit 1) from a locality that is not the owner sets its stored request flag if some locality owns the interface. If none does, the writer becomes owner on the next cycle.
- R3: A release, meaning the owner writes the active bit (bit 5), hands ownership to the highest-numbered locality with a stored request flag. If no such locality exists, the interface becomes unowned.
- R4: A non-owner writing the active bit clears its own request flag and nothing else.
- R5: A seize write (bit 3) is accepted only if no locality owns the interface or the writer's number is above the owner's. It is refused if the writer already has a seize pending or any higher locality has one. Acceptance cancels all lower pending seizes and retargets a waiting hand-over to the writer.
- R6: On a hand-over caused by a seize, the previous owner's been-seized bit (bit 4) becomes 1. On any other hand-over, the previous owner's been-seized bit is unchanged.
- R7: The new owner reads its active bit as 1 and has its request and seize flags cleared. The output loc_changed pulses for exactly the one cycle after each change of owner and at no other time.
- R8: A register read is 8'h80 (valid bit 7) ORed with: the establishment input in bit 0, the reader's request flag in bit 1, bit 2 set when any other locality has a request flag, been-seized in bit 4, and active in bit 5. Bits 3 and 6 read 0.
- R9: Writing 1 to the been-seized bit of a locality clears it.
- R10: If cmd_busy is high when a hand-over becomes due, abort_req rises and the owner holds until a cycle with abort_done high, after which the switch completes and abort_req falls. With cmd_busy low, the switch happens at once. While abort_req is high, only seize and been-seized writes are accepted.
- R11: After reset no locality owns the interface, all flags are clear, and abort_req and loc_changed are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Access register write strobe |
| wr_addr | input | ADDR_W | Write address; the page field selects the locality |
| wr_data | input | 8 | Access register write value |
| rd_addr | input | ADDR_W | Read address; the page field selects the locality |
| rd_data | output | 8 | Access register view of the read locality |
| cmd_busy | input | 1 | A command is executing |
| abort_done | input | 1 | The requested command abort has finished |
| estab_flag | input | 1 | Establishment state shown in bit 0 of every read |
| own_valid | output | 1 | Some locality owns the interface |
| own_loc | output | LOC_W | Owning locality (0 when unowned) |
| abort_req | output | 1 | A hand-over waits for a command abort |
| loc_changed | output | 1 | One-cycle pulse after a change of owner |

## Verification
The bench builds the block with its default parameters: five localities, a 12-bit page offset and a 16-bit address. With these values both the write-ignored locality 4 and the unpopulated localities 5 to 7 can be addressed. The spare address bit 15 lets the bench check that bits above the page field do not affect the locality decode. Four writable localities are enough to set up a seize that retargets a waiting hand-over, to refuse a lower seize while a higher one is pending, and to hand over to the highest of several requesters.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
   // Access register bit positions seen by software
   localparam int B_EST    = 0;
   localparam int B_REQ    = 1;
   localparam int B_PEND   = 2;
   localparam int B_SEIZE  = 3;
   localparam int B_SEIZED = 4;
   localparam int B_ACT    = 5;
   localparam int B_VALID  = 7;
   localparam int ACC_W    = 8;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int LOC_W      = 3,
   parameter int NUM_LOC    = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [LOC_W-1:0]  loc,
   output logic              in_range
);
   localparam int LOC_SPAN = 1 << LOC_W;

   assign loc = addr[PAGE_SHIFT +: LOC_W];

   generate
      if (NUM_LOC >= LOC_SPAN) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_part
         assign in_range = (int'(loc) < NUM_LOC);
      end
   endgenerate
endmodule

// File: rtl/loc_arb_prio.sv
module loc_arb_prio #(
   parameter int N     = 5,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/loc_arb_rdmux.sv
module loc_arb_rdmux
   import loc_arb_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3
) (
   input  logic [LOC_W-1:0]   rloc,
   input  logic               in_range,
   input  logic [NUM_LOC-1:0] req,
   input  logic [NUM_LOC-1:0] seized,
   input  logic               own_vld,
   input  logic [LOC_W-1:0]   own,
   input  logic               estab,
   output logic [ACC_W-1:0]   data
);
   logic [NUM_LOC-1:0] rsel;

   assign rsel = NUM_LOC'(1) << rloc;

   always_comb begin
      data = '0;
      if (!in_range) begin
         data = '1;
      end else begin
         data[B_VALID]  = 1'b1;
         data[B_EST]    = estab;
         data[B_REQ]    = |(req & rsel);
         data[B_PEND]   = |(req & ~rsel);
         data[B_SEIZED] = |(seized & rsel);
         data[B_ACT]    = own_vld && (own == rloc);
      end
   end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
   import loc_arb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int LOC_W      = 3,
   parameter int NUM_LOC    = 5,
   parameter int IGN_LOC    = NUM_LOC - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              cmd_busy,
   input  logic              abort_done,
   input  logic              estab_flag,
   output logic              own_valid,
   output logic [LOC_W-1:0]  own_loc,
   output logic              abort_req,
   output logic              loc_changed
);
   localparam int LOC_SPAN = 1 << LOC_W;

   generate
      if (NUM_LOC < 2 || NUM_LOC > LOC_SPAN) begin : g_bad_num
         $error("loc_arbiter: NUM_LOC must lie in 2..2**LOC_W");
      end
      if (ADDR_W < PAGE_SHIFT + LOC_W) begin : g_bad_addr
         $error("loc_arbiter: address too narrow for the locality field");
      end
   endgenerate

   // ---------------- state ----------------
   logic [NUM_LOC-1:0] req_q, seize_q, seized_q;
   logic               own_vld_q, pend_q, chg_q;
   logic [LOC_W-1:0]   own_q, tgt_q;

   // ---------------- decode ----------------
   logic [LOC_W-1:0] wloc, rloc;
   logic             w_in, r_in;

   loc_arb_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LOC_W(LOC_W),
                    .NUM_LOC(NUM_LOC)) u_wdec (
      .addr(wr_addr), .loc(wloc), .in_range(w_in));

   loc_arb_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LOC_W(LOC_W),
                    .NUM_LOC(NUM_LOC)) u_rdec (
      .addr(rd_addr), .loc(rloc), .in_range(r_in));

   logic             rq_found;
   logic [LOC_W-1:0] rq_idx;

   loc_arb_prio #(.N(NUM_LOC), .IDX_W(LOC_W)) u_prio (
      .vec(req_q), .found(rq_found), .idx(rq_idx));

   // ---------------- write qualification ----------------
   logic               base_ok, sz_ok, act_ok, is_own, seize_ok;
   logic [NUM_LOC-1:0] wsel, below, above;

   assign base_ok = wr_en && w_in && (int'(wloc) != IGN_LOC);
   assign sz_ok   = base_ok && !(pend_q && abort_done);
   assign act_ok  = base_ok && !pend_q;
   assign is_own  = own_vld_q && (own_q == wloc);
   assign wsel    = NUM_LOC'(1) << wloc;
   assign below   = wsel - NUM_LOC'(1);
   assign above   = ~(wsel | below);
   assign seize_ok = (!own_vld_q || (wloc > own_q)) &&
                     !(|(seize_q & wsel)) && !(|(seize_q & above));

   // ---------------- next state ----------------
   logic [NUM_LOC-1:0] n_req, n_sz, n_sd, tsel, osel;
   logic               n_ovld, n_pend, n_chg;
   logic [LOC_W-1:0]   n_own, n_tgt;
   logic               ho_need, now_sw, now_vld, sw, sw_vld;
   logic [LOC_W-1:0]   ho_tgt, now_tgt, sw_tgt;

   always_comb begin
      n_req = req_q;   n_sz = seize_q;  n_sd = seized_q;
      n_ovld = own_vld_q; n_own = own_q;
      n_pend = pend_q; n_tgt = tgt_q; n_chg = 1'b0;
      ho_need = 1'b0;  ho_tgt = '0;
      now_sw = 1'b0;   now_vld = 1'b0; now_tgt = '0;
      sw = 1'b0;       sw_vld = 1'b0;  sw_tgt = '0;
      tsel = '0;       osel = '0;

      if (sz_ok) begin
         if (wr_data[B_SEIZED]) n_sd = n_sd & ~wsel;
         if (wr_data[B_SEIZE]) begin
            if (seize_ok) begin
               n_sz    = (n_sz & ~below) | wsel;
               ho_need = 1'b1;
               ho_tgt  = wloc;
            end
         end else if (act_ok) begin
            if (wr_data[B_ACT]) begin
               if (is_own) begin
                  if (rq_found) begin
                     ho_need = 1'b1;
                     ho_tgt  = rq_idx;
                  end else begin
                     now_sw  = 1'b1;
                  end
               end else begin
                  n_req = n_req & ~wsel;
               end
            end else if (wr_data[B_REQ] && !is_own) begin
               if (own_vld_q) begin
                  n_req = n_req | wsel;
               end else begin
                  now_sw  = 1'b1;
                  now_vld = 1'b1;
                  now_tgt = wloc;
               end
            end
         end
      end

      if (pend_q && abort_done) begin
         sw = 1'b1; sw_vld = 1'b1; sw_tgt = tgt_q; n_pend = 1'b0;
      end else if (ho_need) begin
         if (pend_q || cmd_busy) begin
            n_pend = 1'b1;
            n_tgt  = ho_tgt;
         end else begin
            sw = 1'b1; sw_vld = 1'b1; sw_tgt = ho_tgt;
         end
      end else if (now_sw) begin
         sw = 1'b1; sw_vld = now_vld; sw_tgt = now_tgt;
      end

      if (sw) begin
         tsel  = NUM_LOC'(1) << sw_tgt;
         osel  = NUM_LOC'(1) << own_q;
         n_chg = (sw_vld != own_vld_q) || (sw_vld && (sw_tgt != own_q));
         if (n_chg && own_vld_q) begin
            if (sw_vld && |(n_sz & tsel)) n_sd = n_sd | osel;
            else                          n_req = n_req & ~osel;
         end
         if (sw_vld) begin
            n_req = n_req & ~tsel;
            n_sz  = n_sz & ~tsel;
         end
         n_ovld = sw_vld;
         n_own  = sw_vld ? sw_tgt : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0; seize_q <= '0; seized_q <= '0;
         own_vld_q <= 1'b0; own_q <= '0;
         pend_q <= 1'b0; tgt_q <= '0; chg_q <= 1'b0;
      end else begin
         req_q <= n_req; seize_q <= n_sz; seized_q <= n_sd;
         own_vld_q <= n_ovld; own_q <= n_own;
         pend_q <= n_pend; tgt_q <= n_tgt; chg_q <= n_chg;
      end
   end

   loc_arb_rdmux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rd (
      .rloc(rloc), .in_range(r_in), .req(req_q), .seized(seized_q),
      .own_vld(own_vld_q), .own(own_q), .estab(estab_flag), .data(rd_data));

   assign own_valid   = own_vld_q;
   assign own_loc     = own_q;
   assign abort_req   = pend_q;
   assign loc_changed = chg_q;

   // ---------------- assertions ----------------
   a_r1_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wloc) == IGN_LOC) && !pend_q) |=>
         ($stable(req_q) && $stable(seized_q) && $stable(own_q) && $stable(own_vld_q)));

   a_r2_free_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok && !own_vld_q && wr_data[B_REQ] && !wr_data[B_SEIZE] && !wr_data[B_ACT]) |=>
         (own_valid && (own_loc == $past(wloc))));

   a_r7_change_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      loc_changed |-> ((own_valid != $past(own_valid)) || (own_loc != $past(own_loc))));

   a_r10_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && !abort_done) |=> ($stable(own_valid) && $stable(own_loc)));

   a_r10_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(abort_req) |-> $past(abort_done));

   a_r8_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[B_VALID]);
endmodule

// File: tb/loc_arbiter_bench.sv
`timescale 1ns/100ps
module loc_arbiter_bench;
   localparam int ADDR_W = 16;
   localparam int NVEC   = 22;

   typedef struct packed {
      logic       wr;
      logic [2:0] wloc;
      logic [7:0] wdat;
      logic       busy;
      logic       adone;
      logic [2:0] rloc;
      logic [7:0] exp_rd;
      logic       exp_vld;
      logic [2:0] exp_own;
      logic       exp_abort;
      logic       exp_chg;
      logic [3:0] rq;
   } vec_t;

   // Register bits: 0 establishment, 1 request, 2 pending, 3 seize (write only),
   // 4 been-seized, 5 active, 7 valid.
   localparam vec_t VEC [NVEC] = '{
      '{1'b1,3'd1,8'h02,1'b0,1'b0,3'd1,8'hA0,1'b1,3'd1,1'b0,1'b1,4'd2},  // R2 free grant
      '{1'b1,3'd0,8'h02,1'b0,1'b0,3'd1,8'hA4,1'b1,3'd1,1'b0,1'b0,4'd2},  // R2 latched, R8 pending
      '{1'b1,3'd2,8'h02,1'b0,1'b0,3'd0,8'h86,1'b1,3'd1,1'b0,1'b0,4'd8},  // R8 own + others
      '{1'b1,3'd1,8'h20,1'b0,1'b0,3'd2,8'hA4,1'b1,3'd2,1'b0,1'b1,4'd3},  // R3 highest requester
      '{1'b1,3'd0,8'h20,1'b0,1'b0,3'd0,8'h80,1'b1,3'd2,1'b0,1'b0,4'd4},  // R4 withdraw
      '{1'b1,3'd4,8'h02,1'b0,1'b0,3'd4,8'h80,1'b1,3'd2,1'b0,1'b0,4'd1},  // R1 loc 4 ignored
      '{1'b1,3'd3,8'h08,1'b1,1'b0,3'd3,8'h80,1'b1,3'd2,1'b1,1'b0,4'd10}, // R10 seize deferred
      '{1'b0,3'd0,8'h00,1'b1,1'b0,3'd2,8'hA0,1'b1,3'd2,1'b1,1'b0,4'd10}, // R10 still held
      '{1'b1,3'd1,8'h08,1'b1,1'b0,3'd2,8'hA0,1'b1,3'd2,1'b1,1'b0,4'd5},  // R5 lower refused
      '{1'b0,3'd0,8'h00,1'b0,1'b1,3'd2,8'h90,1'b1,3'd3,1'b0,1'b1,4'd6},  // R6 been-seized
      '{1'b1,3'd2,8'h10,1'b0,1'b0,3'd2,8'h80,1'b1,3'd3,1'b0,1'b0,4'd9},  // R9 clear
      '{1'b1,3'd3,8'h20,1'b0,1'b0,3'd3,8'h80,1'b0,3'd0,1'b0,1'b1,4'd3},  // R3 release to none
      '{1'b1,3'd0,8'h08,1'b0,1'b0,3'd0,8'hA0,1'b1,3'd0,1'b0,1'b1,4'd5},  // R5 seize when free
      '{1'b1,3'd1,8'h02,1'b0,1'b0,3'd0,8'hA4,1'b1,3'd0,1'b0,1'b0,4'd2},  // R2
      '{1'b1,3'd0,8'h20,1'b1,1'b0,3'd0,8'hA4,1'b1,3'd0,1'b1,1'b0,4'd10}, // R10 release deferred
      '{1'b0,3'd0,8'h00,1'b0,1'b1,3'd0,8'h80,1'b1,3'd1,1'b0,1'b1,4'd6},  // R6 normal, R7 flags
      '{1'b1,3'd2,8'h08,1'b1,1'b0,3'd2,8'h80,1'b1,3'd1,1'b1,1'b0,4'd5},  // R5 seize pending
      '{1'b1,3'd3,8'h08,1'b1,1'b0,3'd1,8'hA0,1'b1,3'd1,1'b1,1'b0,4'd5},  // R5 retarget to 3
      '{1'b1,3'd2,8'h08,1'b1,1'b0,3'd1,8'hA0,1'b1,3'd1,1'b1,1'b0,4'd5},  // R5 higher pending
      '{1'b0,3'd0,8'h00,1'b0,1'b1,3'd1,8'h90,1'b1,3'd3,1'b0,1'b1,4'd6},  // R6 seized by 3
      '{1'b1,3'd2,8'h08,1'b0,1'b0,3'd2,8'h80,1'b1,3'd3,1'b0,1'b0,4'd5},  // R5 below owner, R7 no pulse
      '{1'b1,3'd6,8'h02,1'b0,1'b0,3'd6,8'hFF,1'b1,3'd3,1'b0,1'b0,4'd1}   // R1 out of range
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data;
   logic              cmd_busy = 1'b0;
   logic              abort_done = 1'b0;
   logic              estab_flag = 1'b0;
   logic              own_valid;
   logic [2:0]        own_loc;
   logic              abort_req;
   logic              loc_changed;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   loc_arbiter u_loc_arbiter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cmd_busy(cmd_busy), .abort_done(abort_done), .estab_flag(estab_flag),
      .own_valid(own_valid), .own_loc(own_loc), .abort_req(abort_req),
      .loc_changed(loc_changed));

   // Spare bit 15 and page offset bits set: only bits [14:12] pick the locality (R1).
   function automatic logic [ADDR_W-1:0] addr_of(input logic [2:0] l);
      return 16'h8000 | (ADDR_W'(l) << 12) | 16'h03F4;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      rd_addr = addr_of(3'd0);
      @(negedge clk);
      chk("R11", "own_valid", own_valid, 0);
      chk("R11", "abort_req", abort_req, 0);
      chk("R11", "loc_changed", loc_changed, 0);
      chk("R11", "rd_data", rd_data, 8'h80);

      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = $sformatf("R%0d step %0d", VEC[i].rq, i);
         wr_en      = VEC[i].wr;
         wr_addr    = addr_of(VEC[i].wloc);
         wr_data    = VEC[i].wdat;
         cmd_busy   = VEC[i].busy;
         abort_done = VEC[i].adone;
         rd_addr    = addr_of(VEC[i].rloc);
         @(negedge clk);
         wr_en = 1'b0; abort_done = 1'b0;
         chk(tag, "own_valid", own_valid, VEC[i].exp_vld);
         chk(tag, "own_loc", own_loc, VEC[i].exp_own);
         chk(tag, "abort_req", abort_req, VEC[i].exp_abort);
         chk(tag, "loc_changed", loc_changed, VEC[i].exp_chg);
         chk(tag, "rd_data", rd_data, VEC[i].exp_rd);
      end

      // R8 establishment input shown in bit 0; owner 3 reads active
      estab_flag = 1'b1;
      rd_addr = addr_of(3'd3);
      #1;
      chk("R8", "rd_data estab", rd_data, 8'hA1);
      estab_flag = 1'b0;

      // R11 reset from a busy state clears owner and been-seized of locality 1
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_addr = addr_of(3'd1);
      @(negedge clk);
      chk("R11", "own_valid after reset", own_valid, 0);
      chk("R11", "rd_data after reset", rd_data, 8'h80);
      finish_run();
   end
endmodule